// File: doc/BRIEF.md
# SMBus Register Slave with Block Transfers and PEC

This block is a slave on a two-wire SMBus segment. It sits in front of a 256-entry byte register file and lets a host write single bytes and 16-bit words, and move short blocks in either direction. SCL and SDA are taken in as plain inputs. SDA is driven through a single pull-low enable, and the pad itself lives outside the block. The seven-bit slave address has a fixed upper part set by a parameter, and its two lowest bits come from a pair of strap pins.

Each transaction may carry a trailing packet error code. This is a CRC-8 that covers every byte on the wire, starting at the first address byte. On writes the slave checks the code, and a transfer that fails the check is dropped as a whole. To make that possible, incoming data is held in a small buffer and committed to the register file only after the stop condition. On reads the slave appends the code after the payload, and the host may clock it out or leave it. Block transfers use a pointer. The pointer is loaded by any ordinary command byte, including a bare send-byte.

Top module: `smbus_pec_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal {ADDR_HI, addr_sel}. On a mismatch it leaves SDA released for the acknowledge slot and for every later byte until the next start condition.
- R2: A stop condition always returns the slave to idle with SDA released. Out of reset SDA is released and no write strobe is active.
- R3: A write to a command code from 0x00 to 0x7F with one data byte stores that byte at the register whose address is the command code.
- R4: A command code from 0x80 to 0xFB is a word command. A write stores the first data byte at the command code and the second at the command code plus one, and a read returns those two registers in the same order.
- R5: Every command byte other than 0xFC and 0xFD loads the block pointer. Command 0xFC is a block write: a count byte from 1 to MAXB is followed by that many data bytes, and those bytes go to pointer plus 0, 1, 2 and so on. A count of zero or above MAXB is not acknowledged, and nothing is written.
- R6: Command 0xFD, followed by a repeated start with the read bit set, returns a count byte equal to MAXB and then the registers from the pointer upward.
- R7: The error code is a CRC-8 with polynomial x^8+x^2+x+1 and an initial value of zero. It is computed MSB first over every byte from the first address byte onward, and that includes the address byte after a repeated start.
- R8: An error code byte may optionally follow the payload of a write. When it mismatches, that byte is not acknowledged and no register is written. When it matches, or when it is absent, the payload is committed.
- R9: Write strobes occur only after the stop condition, one register per clock on consecutive addresses. A write with fewer data bytes than its command needs commits nothing.
- R10: A byte or word read returns the data and then the error code. After the host answers a byte with not-acknowledge, the slave releases SDA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| addr_sel | input | 2 | Strap pins forming the two low address bits |
| sda_oe | output | 1 | Pull SDA low when high |
| mem_addr | output | 8 | Register file address (read and write) |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe, one register per cycle |
| mem_rdata | input | 8 | Read data for mem_addr, combinational |

## Verification
The bench sweeps every strap setting against every low-address pattern. A decoder that compared the wrong bits would acknowledge a foreign address, or would keep answering after a mismatch. It sends writes whose error code is deliberately off by one bit, and block writes whose count is too large. A design that committed before checking would modify registers there, and one that checked the wrong bytes would also reject good codes. It also sends a word write cut short by a stop, to catch partial commits. Block and word reads compare the returned code with a CRC computed in the bench across the repeated start, which exposes any slave that resets the CRC at the second address.

// File: rtl/smbus_pec_slave.sv
module smbus_pec_slave #(
  parameter logic [4:0] ADDR_HI = 5'b10100,
  parameter int         MAXB    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] addr_sel,
  output logic       sda_oe,
  output logic [7:0] mem_addr,
  output logic [7:0] mem_wdata,
  output logic       mem_we,
  input  logic [7:0] mem_rdata
);
  localparam int         BI = (MAXB > 1) ? $clog2(MAXB) : 1;
  localparam logic [7:0] MB = 8'(MAXB);
  localparam logic [1:0] S_IDLE = 2'd0, S_ADR = 2'd1, S_WR = 2'd2, S_RD = 2'd3;

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ({r[6:0], 1'b0} ^ 8'h07) : {r[6:0], 1'b0};
    return r;
  endfunction

  logic [2:0] scl_q, sda_q;
  logic [1:0] st;
  logic       rw, ackph, mack, tx_on, oe, bad;
  logic [3:0] bcnt;
  logic [7:0] sh, txsh, nb, cmd, ptr, cnt, crc, tidx, ccnt, cidx;
  logic [7:0] buf_q [MAXB];

  wire rise     = scl_q[1] & ~scl_q[2];
  wire fall     = ~scl_q[1] & scl_q[2];
  wire start_ev = scl_q[1] & scl_q[2] & ~sda_q[1] & sda_q[2];
  wire stop_ev  = scl_q[1] & scl_q[2] & sda_q[1] & ~sda_q[2];

  wire        blk     = cmd == 8'hFC;
  wire        brd     = cmd == 8'hFD;
  wire [7:0]  hdr     = blk ? 8'd2 : 8'd1;
  wire [7:0]  dlen    = brd ? 8'd0 : blk ? cnt : cmd[7] ? 8'd2 : 8'd1;
  wire [7:0]  pec_pos = hdr + dlen;
  wire [7:0]  rx_crc  = crc8(crc, sh);
  wire        match   = sh[7:1] == {ADDR_HI, addr_sel};
  wire        wr_data = (nb >= hdr) && (nb < pec_pos);
  wire        cnt_ok  = (sh != 8'd0) && (sh <= MB);
  wire        wr_ack  = (nb == 8'd0) ? 1'b1 :
                        (blk && nb == 8'd1) ? cnt_ok :
                        (wr_data || (nb == pec_pos && rx_crc == 8'd0));
  wire [BI-1:0] kd    = BI'(nb - hdr);
  wire        byte_end = fall && !ackph && bcnt == 4'd8 && !start_ev && !stop_ev;
  wire        commit_ok = st == S_WR && !bad && nb != 8'd0 &&
                          (nb == pec_pos || nb == pec_pos + 8'd1);

  wire [7:0] rhdr    = brd ? 8'd1 : 8'd0;
  wire [7:0] rlen    = brd ? MB : cmd[7] ? 8'd2 : 8'd1;
  wire [7:0] roff    = tidx - rhdr;
  wire [7:0] tx_byte = (tidx < rhdr) ? MB :
                       (tidx < rhdr + rlen) ? mem_rdata :
                       (tidx == rhdr + rlen) ? crc : 8'hFF;

  assign mem_we    = cidx != ccnt;
  assign mem_addr  = mem_we ? ptr + cidx : ptr + roff;
  assign mem_wdata = buf_q[cidx[BI-1:0]];
  assign sda_oe    = oe;

  always_ff @(posedge clk)
    if (byte_end && st == S_WR && wr_data) buf_q[kd] <= sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111; sda_q <= 3'b111; st <= S_IDLE;
      rw <= 1'b0; ackph <= 1'b0; mack <= 1'b0; tx_on <= 1'b0; oe <= 1'b0; bad <= 1'b0;
      bcnt <= '0; sh <= '0; txsh <= '0; nb <= '0; cmd <= '0; ptr <= '0;
      cnt <= '0; crc <= '0; tidx <= '0; ccnt <= '0; cidx <= '0;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
      if (mem_we) cidx <= cidx + 8'd1;
      if (start_ev) begin
        if (st == S_IDLE) crc <= 8'd0;
        st <= S_ADR; bcnt <= '0; ackph <= 1'b0; oe <= 1'b0;
        tx_on <= 1'b0; nb <= '0; bad <= 1'b0; tidx <= '0;
      end else if (stop_ev) begin
        st <= S_IDLE; oe <= 1'b0; tx_on <= 1'b0; ackph <= 1'b0;
        if (commit_ok) begin ccnt <= dlen; cidx <= 8'd0; end
      end else if (st != S_IDLE) begin
        if (rise) begin
          if (ackph) mack <= ~sda_q[1];
          else if (bcnt != 4'd8) begin sh <= {sh[6:0], sda_q[1]}; bcnt <= bcnt + 4'd1; end
        end
        if (fall) begin
          if (ackph) begin
            ackph <= 1'b0; bcnt <= '0; oe <= 1'b0;
            if ((st == S_ADR && rw) || (st == S_RD && mack && tx_on)) begin
              oe <= ~tx_byte[7]; txsh <= {tx_byte[6:0], 1'b0};
              crc <= crc8(crc, tx_byte); tidx <= tidx + 8'd1; tx_on <= 1'b1;
            end else if (st == S_RD) tx_on <= 1'b0;
            if (st == S_ADR) st <= rw ? S_RD : S_WR;
          end else if (bcnt == 4'd8) begin
            ackph <= 1'b1;
            case (st)
              S_ADR: if (match) begin oe <= 1'b1; rw <= sh[0]; crc <= rx_crc; end
                     else st <= S_IDLE;
              S_WR: begin
                oe <= wr_ack; crc <= rx_crc; bad <= bad | ~wr_ack;
                if (nb != 8'hFF) nb <= nb + 8'd1;
                if (nb == 8'd0) begin
                  cmd <= sh;
                  if (sh != 8'hFC && sh != 8'hFD) ptr <= sh;
                end
                if (blk && nb == 8'd1) cnt <= sh;
              end
              default: oe <= 1'b0;
            endcase
          end else if (st == S_RD) begin
            oe <= tx_on & ~txsh[7];
            txsh <= {txsh[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/smbus_pec_slave_chk.sv
module smbus_pec_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       mem_we,
  input logic [7:0] mem_addr,
  input logic [1:0] st,
  input logic       stop_ev
);
  p_oe_rise_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  p_released_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0) |-> !sda_oe);

  p_strobe_after_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(stop_ev));

  p_strobe_consecutive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 8'd1));

  p_no_drive_during_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !sda_oe);
endmodule

bind smbus_pec_slave smbus_pec_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .mem_we(mem_we), .mem_addr(mem_addr), .st(st), .stop_ev(stop_ev)
);

// File: tb/test_smbus_pec_slave.sv
module test_smbus_pec_slave;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 4;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic [1:0] sel = 2'b10;
  logic sda_oe, mem_we;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic sda;
  logic [7:0] mem [256];
  logic [7:0] pl [8];
  logic [7:0] rb [8];
  int n_chk = 0, n_bad = 0, we_cnt = 0;
  bit done = 1'b0;

  assign sda = sda_m & ~sda_oe;
  assign mem_rdata = mem[mem_addr];
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  smbus_pec_slave #(.ADDR_HI(5'b10100), .MAXB(MAXB)) i_smbus_pec_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .addr_sel(sel),
    .sda_oe(sda_oe), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] pec_add(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = r[7] ^ d[i];
      r = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hp();
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic do_start();
    sda_m = 1'b1; hp(); scl = 1'b1; hp(); sda_m = 1'b0; hp(); scl = 1'b0; hp();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; hp(); scl = 1'b1; hp(); sda_m = 1'b1; hp(); hp();
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp(); scl = 1'b1; hp(); scl = 1'b0; hp();
    end
    sda_m = 1'b1; hp(); scl = 1'b1; hp(); ack = ~sda; scl = 1'b0; hp();
  endtask

  task automatic rbyte(input bit ack, output logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; hp(); scl = 1'b1; hp(); d = {d[6:0], sda}; scl = 1'b0; hp();
    end
    sda_m = ack ? 1'b0 : 1'b1; hp(); scl = 1'b1; hp(); scl = 1'b0; hp();
    sda_m = 1'b1;
  endtask

  function automatic logic [6:0] dev();
    return {5'b10100, sel};
  endfunction

  task automatic wr(input int n, input bit pec, input bit corrupt, output int nacks, output bit last_ack);
    logic [7:0] c;
    bit a;
    nacks = 0;
    do_start();
    wbyte({dev(), 1'b0}, a); if (!a) nacks++;
    c = pec_add(8'h00, {dev(), 1'b0});
    for (int i = 0; i < n; i++) begin
      wbyte(pl[i], a); last_ack = a;
      if (!a) nacks++;
      c = pec_add(c, pl[i]);
    end
    if (pec) begin
      wbyte(c ^ (corrupt ? 8'h01 : 8'h00), a); last_ack = a;
      if (!a) nacks++;
    end
    do_stop();
  endtask

  task automatic rd(input logic [7:0] c, input int n, output logic [7:0] pec_exp, output logic oe_after);
    bit a;
    logic [7:0] k;
    do_start();
    wbyte({dev(), 1'b0}, a);
    wbyte(c, a);
    do_start();
    wbyte({dev(), 1'b1}, a);
    k = pec_add(pec_add(pec_add(8'h00, {dev(), 1'b0}), c), {dev(), 1'b1});
    for (int i = 0; i < n; i++) begin
      rbyte(i < n - 1, rb[i]);
      if (i < n - 1) k = pec_add(k, rb[i]);
    end
    pec_exp = k;
    hp();
    oe_after = sda_oe;
    do_stop();
  endtask

  initial begin
    int nk, w0;
    bit la, a, a2;
    logic [7:0] pe;
    logic oa;
    repeat (5) @(posedge clk);
    #1;
    chk("R2 reset sda_oe", {31'd0, sda_oe}, 32'd0);
    chk("R2 reset mem_we", {31'd0, mem_we}, 32'd0);
    rst_n = 1'b1;
    hp();

    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      for (int t = 0; t < 4; t++) begin
        do_start();
        wbyte({5'b10100, 2'(t), 1'b0}, a);
        chk("R1 address match", {31'd0, a}, {31'd0, t == s});
        if (t != s) begin
          wbyte(8'h05, a2);
          chk("R1 ignored after mismatch", {31'd0, a2}, 32'd0);
        end
        do_stop();
      end
    end
    sel = 2'b10;
    do_start(); wbyte({7'h12, 1'b0}, a); do_stop();
    chk("R1 upper bits mismatch", {31'd0, a}, 32'd0);

    w0 = we_cnt;
    pl[0] = 8'h05; pl[1] = 8'hA1; wr(2, 0, 0, nk, la);
    chk("R3 byte write acks", nk, 0);
    chk("R3 byte write data", mem[8'h05], 8'hA1);
    chk("R9 one strobe", we_cnt - w0, 1);

    pl[0] = 8'h06; pl[1] = 8'h3C; wr(2, 1, 0, nk, la);
    chk("R8 good pec ack", {31'd0, la}, 32'd1);
    chk("R7 byte write with pec", mem[8'h06], 8'h3C);

    w0 = we_cnt;
    pl[0] = 8'h07; pl[1] = 8'h11; wr(2, 1, 1, nk, la);
    chk("R8 bad pec nack", {31'd0, la}, 32'd0);
    chk("R8 bad pec no write", mem[8'h07], 8'h07 ^ 8'h5A);
    chk("R8 bad pec no strobe", we_cnt - w0, 0);

    pl[0] = 8'h90; pl[1] = 8'h12; pl[2] = 8'h34; wr(3, 1, 0, nk, la);
    chk("R4 word acks", nk, 0);
    chk("R4 word low", mem[8'h90], 8'h12);
    chk("R4 word high", mem[8'h91], 8'h34);

    w0 = we_cnt;
    pl[0] = 8'h92; pl[1] = 8'h77; wr(2, 0, 0, nk, la);
    chk("R9 short word no write", mem[8'h92], 8'h92 ^ 8'h5A);
    chk("R9 short word no strobe", we_cnt - w0, 0);

    w0 = we_cnt;
    pl[0] = 8'h20; wr(1, 0, 0, nk, la);
    pl[0] = 8'hFC; pl[1] = 8'd3; pl[2] = 8'hB0; pl[3] = 8'hB1; pl[4] = 8'hB2;
    wr(5, 1, 0, nk, la);
    chk("R5 block acks", nk, 0);
    chk("R5 block byte0", mem[8'h20], 8'hB0);
    chk("R5 block byte2", mem[8'h22], 8'hB2);
    chk("R9 block strobes", we_cnt - w0, 3);

    w0 = we_cnt;
    pl[0] = 8'hFC; pl[1] = 8'd2; pl[2] = 8'hC0; pl[3] = 8'hC1; wr(4, 1, 1, nk, la);
    chk("R8 block bad pec nack", {31'd0, la}, 32'd0);
    chk("R8 block bad pec no write", mem[8'h20], 8'hB0);

    pl[0] = 8'hFC; pl[1] = 8'd5; wr(2, 0, 0, nk, la);
    chk("R5 count too large nack", {31'd0, la}, 32'd0);
    chk("R5 no strobe on bad count", we_cnt - w0, 0);

    rd(8'hFD, MAXB + 2, pe, oa);
    chk("R6 block read count", rb[0], MAXB);
    chk("R6 block read d0", rb[1], 8'hB0);
    chk("R6 block read d3", rb[4], 8'h23 ^ 8'h5A);
    chk("R7 block read pec", rb[MAXB + 1], pe);
    chk("R10 release after nack", {31'd0, oa}, 32'd0);

    rd(8'h05, 2, pe, oa);
    chk("R10 byte read data", rb[0], 8'hA1);
    chk("R10 byte read pec", rb[1], pe);

    rd(8'h90, 3, pe, oa);
    chk("R4 word read low", rb[0], 8'h12);
    chk("R4 word read high", rb[1], 8'h34);
    chk("R7 word read pec", rb[2], pe);

    rd(8'h90, 1, pe, oa);
    chk("R10 early nack release", {31'd0, oa}, 32'd0);
    chk("R2 idle after stop", {31'd0, sda_oe}, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule